// File: doc/BRIEF.md
# Two-Channel Decimation Phase Aligner

This block schedules the decimation boundaries of two decimating converter channels so that their results come out with a fixed, programmable skew. It runs from a modulator-clock enable (`tick`). Channel 1 is the reference. It strobes a boundary once per oversampling period from a free-running counter. Channel 0 strobes at a point inside the same period that is set by a signed phase value. At its own boundary, each channel latches a ready-made 16-bit filter result from its input and then raises a one-clock data-ready pulse.

The phase value is written once at full width. When a smaller oversampling ratio is selected, only the low log2(OSR) bits are read as a signed value, so the sign bit moves down and the upper bits are ignored. A new phase or ratio setting takes effect at the next Channel 1 boundary. An active-low hard reset clears both result latches and all strobes, and returns the settings to phase 0 and OSR 256. Writes made while the reset is held are dropped.

Top module: `dual_phase_aligner`

## Requirements
- R1: While `rst_n` is low, `data0` and `data1` read 0x0000 and `bnd0`, `bnd1`, `drdy0` and `drdy1` stay low, from the clock after the first reset edge onward.
- R2: After reset the settings are OSR 256 and phase 0, and any `cfg_we` pulse that occurs while `rst_n` is low has no effect on either of them.
- R3: `osr_sel` codes 0, 1, 2 and 3 select OSR 32, 64, 128 and 256. `bnd1` pulses once every OSR ticks.
- R4: Take p as the effective signed phase. In steady state, Channel 0's boundary lands p ticks after Channel 1's when p > 0 (Channel 0 lags) and |p| ticks before it when p < 0 (Channel 0 leads). When p = 0 the two boundaries land on the same clock.
- R5: The effective phase is `phase_in` bits [log2(OSR)-1:0] read as two's complement. Bit 7 is the sign at OSR 256, bit 6 at 128, bit 5 at 64 and bit 4 at 32. Higher bits are ignored, so the range is -OSR/2 to OSR/2-1.
- R6: On the clock edge where `bnd_k` rises, `data_k` loads the value that `resk_in` held before that edge. At all other times `data_k` holds its value.
- R7: Each boundary strobe and each data-ready pulse is one clock wide. `drdy_k` is high on the clock right after `bnd_k`.
- R8: A write to the phase or OSR setting does not change the boundary timing until the next `bnd1`. The period that is in progress finishes at the old ratio.
- R9: After reset is released with `tick` held high, the first `drdy1` comes 257 clocks after release. Channel 0 produces no boundary before the first Channel 1 boundary.
- R10: The counter advances only on clocks where `tick` is high. Without a tick, no boundary is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| tick | input | 1 | Modulator-clock enable, one per modulator clock |
| cfg_we | input | 1 | Write strobe for the ratio and phase settings |
| osr_sel | input | 2 | Ratio select: 0=32, 1=64, 2=128, 3=256 |
| phase_in | input | 8 | Phase value, two's complement, full width |
| res0_in | input | 16 | Channel 0 filter result word |
| res1_in | input | 16 | Channel 1 filter result word |
| bnd0 | output | 1 | Channel 0 decimation boundary strobe |
| bnd1 | output | 1 | Channel 1 decimation boundary strobe |
| drdy0 | output | 1 | Channel 0 data-ready pulse |
| drdy1 | output | 1 | Channel 1 data-ready pulse |
| data0 | output | 16 | Channel 0 latched result |
| data1 | output | 16 | Channel 1 latched result |

## Verification
The assertions check local rules on every cycle:
- outputs are cleared under reset;
- the counter stays below the active period length and freezes when there is no tick;
- active settings change only at a Channel 1 boundary;
- each strobe is followed by a single data-ready pulse;
- the result latches hold between boundaries.

The bench scenarios show the rules that depend on time and history:
- the measured skew for positive, negative and zero phase;
- the sign bit moving with each ratio;
- a mid-period write that leaves the current period intact;
- settings written during reset being ignored;
- the exact delay to the first data-ready pulse after release.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int DPA_DATA_W  = 16;
    localparam int DPA_SEL_W   = 2;
    localparam int DPA_LOG_MIN = 5;

    // Ratio select codes; OSR = 2**(DPA_LOG_MIN + code)
    typedef enum logic [DPA_SEL_W-1:0] {
        OSR_32  = 2'd0,
        OSR_64  = 2'd1,
        OSR_128 = 2'd2,
        OSR_256 = 2'd3
    } osr_code_e;

    // Counter width for the largest ratio
    function automatic int cnt_width(input int sel_w, input int log_min);
        return log_min + (1 << sel_w) - 1;
    endfunction

endpackage

// File: rtl/dpa_cfg.sv
// Holds the written settings and the active copy that the scheduler uses.
// The active copy is refreshed only on the reference boundary.
module dpa_cfg #(
    parameter int SEL_W   = 2,
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [PHASE_W-1:0] wr_phase,
    input  logic               load,
    output logic [SEL_W-1:0]   act_sel,
    output logic [PHASE_W-1:0] act_phase
);

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [PHASE_W-1:0] phase;
        logic [SEL_W-1:0]   act_sel;
        logic [PHASE_W-1:0] act_phase;
    } cfg_st_t;

    localparam cfg_st_t RESET_ST = '{
        sel:       {SEL_W{1'b1}},
        phase:     '0,
        act_sel:   {SEL_W{1'b1}},
        act_phase: '0
    };

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.act_sel   = st_q.sel;
            st_d.act_phase = st_q.phase;
        end
        if (wr_en) begin
            st_d.sel   = wr_sel;
            st_d.phase = wr_phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_sel   = st_q.act_sel;
    assign act_phase = st_q.act_phase;

    AST_ACT_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> ($stable(act_sel) && $stable(act_phase))); // R8

endmodule

// File: rtl/dpa_osr_decode.sv
// Turns the active ratio code and phase into the period's last count and the
// count on which Channel 0 strikes. One variant is built per ratio code.
module dpa_osr_decode #(
    parameter int SEL_W   = 2,
    parameter int LOG_MIN = 5,
    parameter int CNT_W   = 8,
    parameter int PHASE_W = 8
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [PHASE_W-1:0] phase,
    output logic [CNT_W-1:0]   last,
    output logic [CNT_W-1:0]   target
);

    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_v [NSEL];
    logic [CNT_W-1:0] tgt_v  [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_ratio
        localparam int LG = LOG_MIN + i;
        logic [LG-1:0] trunc_m1;
        // Low LG bits modulo 2**LG equal the signed value modulo OSR;
        // minus one aligns a zero phase onto the reference boundary.
        assign trunc_m1  = phase[LG-1:0] - LG'(1);
        assign tgt_v[i]  = CNT_W'(trunc_m1);
        assign last_v[i] = CNT_W'((1 << LG) - 1);
    end

    assign last   = last_v[sel];
    assign target = tgt_v[sel];

endmodule

// File: rtl/dpa_sched.sv
// Free-running modulo-OSR counter producing both channels' boundary hits.
module dpa_sched #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] target,
    output logic             hit0,
    output logic             hit1
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } sched_st_t;

    sched_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit1 = tick && (st_q.cnt == last);
        hit0 = tick && st_q.armed && (st_q.cnt == target);
        if (tick) begin
            st_d.cnt = hit1 ? '0 : st_q.cnt + CNT_W'(1);
        end
        if (hit1) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last); // R3

    AST_CNT_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && $past(rst_n)) |=> $stable(st_q.cnt)); // R10

endmodule

// File: rtl/dpa_chan.sv
// One channel's boundary strobe, result latch and data-ready pulse.
module dpa_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] res_in,
    output logic              bnd,
    output logic              drdy,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              bnd;
        logic              drdy;
        logic [DATA_W-1:0] data;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bnd  = hit;
        st_d.drdy = st_q.bnd;
        if (hit) begin
            st_d.data = res_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bnd  = st_q.bnd;
    assign drdy = st_q.drdy;
    assign data = st_q.data;

    AST_DRDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bnd |=> drdy); // R7

    AST_DRDY_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |=> !drdy); // R7

    AST_DATA_HELD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |-> $stable(data)); // R6

endmodule

// File: rtl/dual_phase_aligner.sv
module dual_phase_aligner
    import dpa_pkg::*;
#(
    parameter int DATA_W  = DPA_DATA_W,
    parameter int SEL_W   = DPA_SEL_W,
    parameter int LOG_MIN = DPA_LOG_MIN,
    parameter int PHASE_W = cnt_width(DPA_SEL_W, DPA_LOG_MIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   osr_sel,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic [DATA_W-1:0]  res0_in,
    input  logic [DATA_W-1:0]  res1_in,
    output logic               bnd0,
    output logic               bnd1,
    output logic               drdy0,
    output logic               drdy1,
    output logic [DATA_W-1:0]  data0,
    output logic [DATA_W-1:0]  data1
);

    localparam int CNT_W = cnt_width(SEL_W, LOG_MIN);
    localparam int NCH   = 2;

    logic [SEL_W-1:0]   act_sel;
    logic [PHASE_W-1:0] act_phase;
    logic [CNT_W-1:0]   last, target;
    logic [NCH-1:0]     hit, bnd_v, drdy_v;
    logic [DATA_W-1:0]  res_v  [NCH];
    logic [DATA_W-1:0]  data_v [NCH];

    dpa_cfg #(.SEL_W(SEL_W), .PHASE_W(PHASE_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_sel   (osr_sel),
        .wr_phase (phase_in),
        .load     (hit[1]),
        .act_sel  (act_sel),
        .act_phase(act_phase)
    );

    dpa_osr_decode #(.SEL_W(SEL_W), .LOG_MIN(LOG_MIN), .CNT_W(CNT_W), .PHASE_W(PHASE_W)) i_dec (
        .sel   (act_sel),
        .phase (act_phase),
        .last  (last),
        .target(target)
    );

    dpa_sched #(.CNT_W(CNT_W)) i_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .last  (last),
        .target(target),
        .hit0  (hit[0]),
        .hit1  (hit[1])
    );

    assign res_v[0] = res0_in;
    assign res_v[1] = res1_in;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dpa_chan #(.DATA_W(DATA_W)) i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[c]),
            .res_in(res_v[c]),
            .bnd   (bnd_v[c]),
            .drdy  (drdy_v[c]),
            .data  (data_v[c])
        );
    end

    assign bnd0  = bnd_v[0];
    assign bnd1  = bnd_v[1];
    assign drdy0 = drdy_v[0];
    assign drdy1 = drdy_v[1];
    assign data0 = data_v[0];
    assign data1 = data_v[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (data0 == '0 && data1 == '0 && !bnd0 && !bnd1 && !drdy0 && !drdy1)); // R1

endmodule

// File: tb/test_dual_phase_aligner.sv
module test_dual_phase_aligner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  osr_sel = 2'd0;
    logic [7:0]  phase_in = 8'd0;
    logic [15:0] res0_in = 16'h1234;
    logic [15:0] res1_in = 16'hABCD;
    logic        bnd0, bnd1, drdy0, drdy1;
    logic [15:0] data0, data1;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    bit  half_rate = 1'b0;
    bit  done = 1'b0;

    // Reference model state
    int          m_cnt, v, tgt, osr;
    bit          m_armed;
    logic [1:0]  m_sel, a_sel;
    logic [7:0]  m_ph, a_ph;
    bit          e_bnd0, e_bnd1, e_drdy0, e_drdy1, h0, h1;
    logic [15:0] e_d0, e_d1;

    dual_phase_aligner i_dual_phase_aligner (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
        .osr_sel(osr_sel), .phase_in(phase_in),
        .res0_in(res0_in), .res1_in(res1_in),
        .bnd0(bnd0), .bnd1(bnd1), .drdy0(drdy0), .drdy1(drdy1),
        .data0(data0), .data1(data1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: period position, arm flag, settings taken at reference boundary
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_armed = 0; m_sel = 2'd3; m_ph = 8'd0; a_sel = 2'd3; a_ph = 8'd0;
            e_bnd0 = 0; e_bnd1 = 0; e_drdy0 = 0; e_drdy1 = 0; e_d0 = 16'd0; e_d1 = 16'd0;
        end else begin
            e_drdy0 = e_bnd0;
            e_drdy1 = e_bnd1;
            e_bnd0 = 0;
            e_bnd1 = 0;
            if (tick) begin
                osr = 1 << (5 + int'(a_sel));
                v = int'(a_ph) % osr;
                if (v >= osr / 2) v = v - osr;
                tgt = (v - 1 + osr) % osr;
                h1 = (m_cnt == osr - 1);
                h0 = m_armed && (m_cnt == tgt);
                if (h1) begin e_bnd1 = 1; e_d1 = res1_in; end
                if (h0) begin e_bnd0 = 1; e_d0 = res0_in; end
                m_cnt = h1 ? 0 : m_cnt + 1;
                if (h1) begin m_armed = 1; a_sel = m_sel; a_ph = m_ph; end
            end
            if (cfg_we) begin m_sel = osr_sel; m_ph = phase_in; end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            chk(bnd1 == e_bnd1, "R3 bnd1", bnd1, e_bnd1);
            chk(bnd0 == e_bnd0, "R4 bnd0", bnd0, e_bnd0);
            chk(drdy1 == e_drdy1, "R7 drdy1", drdy1, e_drdy1);
            chk(drdy0 == e_drdy0, "R7 drdy0", drdy0, e_drdy0);
            chk(data1 == e_d1, "R6 data1", data1, e_d1);
            chk(data0 == e_d0, "R6 data0", data0, e_d0);
        end
    end

    // Result words and tick pattern driven after the falling edge
    always @(negedge clk) begin
        #1;
        res0_in <= res0_in * 16'd5 + 16'd7;
        res1_in <= {res1_in[14:0], res1_in[15] ^ res1_in[13]} + 16'd3;
        tick    <= half_rate ? ~tick : 1'b1;
    end

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic write_cfg(input logic [1:0] s, input logic [7:0] p);
        @(negedge clk); #1;
        osr_sel = s; phase_in = p; cfg_we = 1'b1;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_drdy1(output int c);
        c = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk); #2;
            if (drdy1) begin c = cyc; break; end
        end
    endtask

    task automatic check_skew(input int exp, input string tag);
        int c1 = -1, c0 = -1, diff;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk); #2;
            if (drdy0) c0 = cyc;
            if (drdy1) begin c1 = cyc; break; end
        end
        if (exp >= 0) begin
            for (int k = 0; k < 600; k++) begin
                if (drdy0) begin c0 = cyc; break; end
                @(negedge clk); #2;
            end
            diff = c0 - c1;
        end else begin
            diff = c0 - c1;
        end
        chk(diff == exp, tag, diff, exp);
    endtask

    task automatic settle();
        int c;
        wait_drdy1(c);
        wait_drdy1(c);
    endtask

    initial begin
        int rel, c_a, c_b, c_c;
        // Reset with a write that must be ignored
        cfg_we = 1'b1; osr_sel = 2'd0; phase_in = 8'h05;
        step(4);
        chk(data0 == 0 && data1 == 0, "R1 data in reset", {data0, data1}, 0);
        chk(!bnd0 && !bnd1 && !drdy0 && !drdy1, "R1 strobes in reset",
            {bnd0, bnd1, drdy0, drdy1}, 0);
        cfg_we = 1'b0;
        step(1);
        rst_n = 1'b1;
        rel = cyc;
        wait_drdy1(c_a);
        chk(c_a - rel == 257, "R9 first drdy1 delay", c_a - rel, 257);
        wait_drdy1(c_b);
        chk(c_b - c_a == 256, "R2 default ratio kept", c_b - c_a, 256);
        check_skew(0, "R2 default phase kept");

        write_cfg(2'd3, 8'h05); settle();
        check_skew(5, "R4 lag +5 at OSR 256");
        write_cfg(2'd3, 8'hFD); settle();
        check_skew(-3, "R4 lead -3 at OSR 256");

        write_cfg(2'd0, 8'h90); settle();
        check_skew(-16, "R5 bit4 sign at OSR 32");
        write_cfg(2'd0, 8'h2F); settle();
        check_skew(15, "R5 upper bits ignored at OSR 32");
        write_cfg(2'd1, 8'h7F); settle();
        check_skew(-1, "R5 bit5 sign at OSR 64");
        wait_drdy1(c_a); wait_drdy1(c_b);
        chk(c_b - c_a == 64, "R3 period at OSR 64", c_b - c_a, 64);
        write_cfg(2'd2, 8'h40); settle();
        check_skew(-64, "R5 bit6 sign at OSR 128");

        // Mid-period change keeps current period
        write_cfg(2'd1, 8'h00); settle();
        wait_drdy1(c_a);
        step(10);
        write_cfg(2'd0, 8'h00);
        wait_drdy1(c_b);
        wait_drdy1(c_c);
        chk(c_b - c_a == 64, "R8 running period unchanged", c_b - c_a, 64);
        chk(c_c - c_b == 32, "R8 new ratio after boundary", c_c - c_b, 32);

        // Ticks on every other clock
        half_rate = 1'b1;
        settle();
        wait_drdy1(c_a); wait_drdy1(c_b);
        chk(c_b - c_a == 64, "R10 period counts ticks only", c_b - c_a, 64);
        half_rate = 1'b0;
        step(3);

        // Reset mid-run
        rst_n = 1'b0;
        step(2);
        chk(data0 == 0 && data1 == 0, "R1 data cleared mid-run", {data0, data1}, 0);
        chk(!drdy0 && !drdy1, "R1 drdy cleared mid-run", {drdy0, drdy1}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule